// File: doc/BRIEF.md
# Flash Security Gate with Key Unlock

This block decides whether the flash of a microcontroller is locked against outside access. While reset is held it copies two nonvolatile bytes, a protection byte and an option byte, into working registers. The working copies then set the block protection outputs and the security state for the whole time between resets. Changes on the nonvolatile inputs after reset has ended do not reach the working copies.

Security can be lifted in two ways. The first is a backdoor key: CPU code writes eight key bytes in order, and the block compares them against the stored 64-bit key. This works only when the key-enable option bit is set, and writes that arrive from the debug side are ignored. The second is a mass erase followed by a passing blank check, both reported by the debug side. Either unlock lasts only until the next reset. While the part is locked, an output tells the debug interface to refuse flash reads.

Top module: `flash_sec_ctrl`

## Requirements
- R1: While `rst_n` is low the working protection and option registers load `nv_prot_i` and `nv_opt_i`. After reset ends they hold their values whatever the nonvolatile inputs do.
- R2: `prot_en_o` is the inverse of bit 0 of the working protection byte, and `prot_start_o` is bits 7..1 of that byte.
- R3: After reset, `secure_o` is 0 only when bits 1:0 of the working option byte equal 2'b10. The other three encodings give `secure_o` = 1.
- R4: When option bit 7 (key enable) is 1 and the part is secure, CPU writes (`key_dbg_i` = 0) of key bytes 0 to 7 in order, each equal to `nv_key_i[8*i+7:8*i]`, clear `secure_o` in the cycle after the eighth write. It stays 0 until the next reset.
- R5: When option bit 7 is 0, key writes have no effect: `secure_o` stays 1 and `key_fail_o` stays 0.
- R6: A key write with `key_dbg_i` = 1 is ignored. It changes neither the position in the sequence nor the lockout, and it never raises `key_fail_o`.
- R7: An accepted key write whose index is not the next expected one, or an eighth byte that ends an attempt containing any mismatching byte, raises `key_fail_o` for exactly one cycle. After that the key path is locked out and even a correct key is ignored until reset.
- R8: A `blank_done_i` strobe with `blank_pass_i` = 1 clears `secure_o` in the next cycle only if a `mass_erase_i` strobe came earlier and no blank check has completed since. A failing blank check, or a blank check with no prior erase, leaves the part secure.
- R9: `debug_block_o` is high exactly when `secure_o` is high.
- R10: A reset after any unlock takes the security state again from the nonvolatile option bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; nonvolatile bytes load while it is low |
| nv_prot_i | input | 8 | Nonvolatile protection byte image |
| nv_opt_i | input | 8 | Nonvolatile option byte image |
| nv_key_i | input | 64 | Stored backdoor key, byte i in bits 8i+7..8i |
| key_wr_i | input | 1 | Key byte write strobe |
| key_dbg_i | input | 1 | Origin of the write: 1 = debug side, 0 = CPU |
| key_idx_i | input | 3 | Index of the key byte being written |
| key_data_i | input | 8 | Key byte value |
| mass_erase_i | input | 1 | Strobe: mass erase finished |
| blank_done_i | input | 1 | Strobe: blank check finished |
| blank_pass_i | input | 1 | Blank check result, valid with blank_done_i |
| secure_o | output | 1 | Registered security state |
| debug_block_o | output | 1 | Deny debug flash reads |
| key_fail_o | output | 1 | One-cycle pulse on a failed key attempt |
| prot_en_o | output | 1 | Block protection enabled |
| prot_start_o | output | 7 | Protection start field |
| opt_o | output | 8 | Working option register |

## Verification
A wrong sequence pointer or a mismatch flag that fails to clear shows up at the ports on the eighth byte of the next attempt. `secure_o` then fails to fall one cycle after a correct key, or `key_fail_o` pulses when it should not. A lockout flag that is set wrongly or missed appears only on the attempt that follows a failure, so the bench always retries with the correct key after every failure. A stale erase flag appears one cycle after the blank-check strobe.

// File: rtl/fsec_pkg.sv
package fsec_pkg;
    localparam int BYTE_W     = 8;
    localparam int KEY_BYTES  = 8;
    localparam int KEYEN_BIT  = 7;
    localparam logic [1:0] SEC_OPEN = 2'b10;

    function automatic logic field_locked(input logic [1:0] f);
        return f != SEC_OPEN;
    endfunction

    typedef struct packed {
        logic [BYTE_W-1:0] prot;
        logic [BYTE_W-1:0] opt;
    } shadow_t;

    typedef struct packed {
        logic secure;
        logic unlocked;
        logic erased;
        logic fail;
    } sec_st_t;
endpackage

// File: rtl/fsec_shadow.sv
module fsec_shadow
    import fsec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] nv_prot_i,
    input  logic [BYTE_W-1:0] nv_opt_i,
    output logic [BYTE_W-1:0] prot_o,
    output logic [BYTE_W-1:0] opt_o
);
    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (!rst_n) begin
            sh_d.prot = nv_prot_i;
            sh_d.opt  = nv_opt_i;
        end
    end

    always_ff @(posedge clk) sh_q <= sh_d;

    assign prot_o = sh_q.prot;
    assign opt_o  = sh_q.opt;

    // R1
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(sh_q));
endmodule

// File: rtl/fsec_keycmp.sv
module fsec_keycmp
    import fsec_pkg::*;
#(
    parameter int NB = KEY_BYTES,
    parameter int BW = BYTE_W,
    localparam int IW = $clog2(NB)
)(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           allow_i,
    input  logic           wr_i,
    input  logic           dbg_i,
    input  logic [IW-1:0]  idx_i,
    input  logic [BW-1:0]  data_i,
    input  logic [NB*BW-1:0] key_i,
    output logic           hit_o,
    output logic           miss_o
);
    localparam logic [IW-1:0] LAST = IW'(NB - 1);

    typedef struct packed {
        logic [IW-1:0] ptr;
        logic          miss;
        logic          lock;
    } kc_t;

    kc_t kc_d, kc_q;
    logic accept, bad_byte, miss_acc;
    logic [BW-1:0] want;

    assign want     = key_i[int'(kc_q.ptr)*BW +: BW];
    assign accept   = wr_i && !dbg_i && allow_i && !kc_q.lock;
    assign bad_byte = data_i != want;
    assign miss_acc = kc_q.miss || bad_byte;

    always_comb begin
        kc_d   = kc_q;
        hit_o  = 1'b0;
        miss_o = 1'b0;
        if (!rst_n) begin
            kc_d = '0;
        end else if (accept) begin
            if (idx_i != kc_q.ptr) begin
                miss_o    = 1'b1;
                kc_d.lock = 1'b1;
                kc_d.ptr  = '0;
                kc_d.miss = 1'b0;
            end else if (kc_q.ptr == LAST) begin
                hit_o     = !miss_acc;
                miss_o    = miss_acc;
                kc_d.lock = miss_acc;
                kc_d.ptr  = '0;
                kc_d.miss = 1'b0;
            end else begin
                kc_d.ptr  = kc_q.ptr + 1'b1;
                kc_d.miss = miss_acc;
            end
        end
    end

    always_ff @(posedge clk) kc_q <= kc_d;

    // R6
    dbg_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && dbg_i) |=> $stable(kc_q));
    // R7
    lockout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kc_q.lock |=> kc_q.lock);
    // R7
    locked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kc_q.lock |-> !(hit_o || miss_o));
endmodule

// File: rtl/fsec_state.sv
module fsec_state
    import fsec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rst_locked_i,
    input  logic wk_locked_i,
    input  logic key_en_i,
    input  logic key_hit_i,
    input  logic key_miss_i,
    input  logic mass_erase_i,
    input  logic blank_done_i,
    input  logic blank_pass_i,
    output logic secure_o,
    output logic fail_o
);
    sec_st_t st_d, st_q;
    logic blank_unlock;

    assign blank_unlock = blank_done_i && blank_pass_i && st_q.erased;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.unlocked = 1'b0;
            st_d.erased   = 1'b0;
            st_d.fail     = 1'b0;
            st_d.secure   = rst_locked_i;
        end else begin
            st_d.unlocked = st_q.unlocked || key_hit_i || blank_unlock;
            if (mass_erase_i)
                st_d.erased = 1'b1;
            else if (blank_done_i)
                st_d.erased = 1'b0;
            st_d.fail   = key_miss_i;
            st_d.secure = wk_locked_i && !st_d.unlocked;
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign secure_o = st_q.secure;
    assign fail_o   = st_q.fail;

    // R4
    unlock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !secure_o |=> !secure_o);
    // R3
    open_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wk_locked_i |-> !secure_o);
    // R5
    keyoff_nofail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !key_en_i |-> !fail_o);
    // R7
    fail_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> !fail_o);
endmodule

// File: rtl/flash_sec_ctrl.sv
module flash_sec_ctrl
    import fsec_pkg::*;
#(
    parameter int NB = KEY_BYTES,
    parameter int BW = BYTE_W,
    localparam int IW = $clog2(NB)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BW-1:0]    nv_prot_i,
    input  logic [BW-1:0]    nv_opt_i,
    input  logic [NB*BW-1:0] nv_key_i,
    input  logic             key_wr_i,
    input  logic             key_dbg_i,
    input  logic [IW-1:0]    key_idx_i,
    input  logic [BW-1:0]    key_data_i,
    input  logic             mass_erase_i,
    input  logic             blank_done_i,
    input  logic             blank_pass_i,
    output logic             secure_o,
    output logic             debug_block_o,
    output logic             key_fail_o,
    output logic             prot_en_o,
    output logic [BW-2:0]    prot_start_o,
    output logic [BW-1:0]    opt_o
);
    logic [BW-1:0] wk_prot, wk_opt;
    logic key_en, hit, miss;

    fsec_shadow u_shadow (
        .clk(clk), .rst_n(rst_n),
        .nv_prot_i(nv_prot_i), .nv_opt_i(nv_opt_i),
        .prot_o(wk_prot), .opt_o(wk_opt)
    );

    assign key_en = wk_opt[KEYEN_BIT];

    fsec_keycmp #(.NB(NB), .BW(BW)) u_keycmp (
        .clk(clk), .rst_n(rst_n),
        .allow_i(key_en && secure_o),
        .wr_i(key_wr_i), .dbg_i(key_dbg_i),
        .idx_i(key_idx_i), .data_i(key_data_i), .key_i(nv_key_i),
        .hit_o(hit), .miss_o(miss)
    );

    fsec_state u_state (
        .clk(clk), .rst_n(rst_n),
        .rst_locked_i(field_locked(nv_opt_i[1:0])),
        .wk_locked_i(field_locked(wk_opt[1:0])),
        .key_en_i(key_en),
        .key_hit_i(hit), .key_miss_i(miss),
        .mass_erase_i(mass_erase_i),
        .blank_done_i(blank_done_i), .blank_pass_i(blank_pass_i),
        .secure_o(secure_o), .fail_o(key_fail_o)
    );

    assign debug_block_o = secure_o;
    assign prot_en_o     = !wk_prot[0];
    assign prot_start_o  = wk_prot[BW-1:1];
    assign opt_o         = wk_opt;

    // R9
    dbg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        debug_block_o == secure_o);
endmodule

// File: tb/flash_sec_ctrl_test.sv
module flash_sec_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] nv_prot = 8'h00, nv_opt = 8'h80;
    logic [63:0] nv_key;
    logic key_wr = 0, key_dbg = 0;
    logic [2:0] key_idx = 0;
    logic [7:0] key_data = 0;
    logic mass_erase = 0, blank_done = 0, blank_pass = 0;
    logic secure, debug_block, key_fail, prot_en;
    logic [6:0] prot_start;
    logic [7:0] opt;
    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    flash_sec_ctrl uut (
        .clk(clk), .rst_n(rst_n), .nv_prot_i(nv_prot), .nv_opt_i(nv_opt),
        .nv_key_i(nv_key), .key_wr_i(key_wr), .key_dbg_i(key_dbg),
        .key_idx_i(key_idx), .key_data_i(key_data), .mass_erase_i(mass_erase),
        .blank_done_i(blank_done), .blank_pass_i(blank_pass),
        .secure_o(secure), .debug_block_o(debug_block), .key_fail_o(key_fail),
        .prot_en_o(prot_en), .prot_start_o(prot_start), .opt_o(opt)
    );

    function automatic logic [7:0] kb(input int i);
        return 8'(8'h3C ^ (i * 37));
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] p, input logic [7:0] o);
        @(negedge clk);
        nv_prot = p; nv_opt = o; rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    // one write; returns at the negedge after the capturing edge
    task automatic wr(input int idx, input logic [7:0] d, input logic dbg);
        key_wr = 1; key_idx = 3'(idx); key_data = d; key_dbg = dbg;
        @(negedge clk);
        key_wr = 0; key_dbg = 0;
    endtask

    task automatic full_key(input int bad_pos, input logic dbg);
        for (int i = 0; i < 8; i++)
            wr(i, (i == bad_pos) ? ~kb(i) : kb(i), dbg);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) nv_key[8*i +: 8] = kb(i);
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R2 sweep all protection bytes; R3 sweep security field x key enable
        for (int p = 0; p < 256; p++) begin
            do_reset(8'(p), 8'h80);
            chk(prot_en == !p[0] && prot_start == 7'(p >> 1), "R2", {prot_en, prot_start}, {!p[0], 7'(p >> 1)});
        end
        for (int o = 0; o < 8; o++) begin
            logic [7:0] ov;
            ov = {o[2], 5'b0, o[1:0]};
            do_reset(8'h00, ov);
            @(negedge clk);
            chk(opt == ov, "R1", opt, ov);
            chk(secure == (o[1:0] != 2'b10), "R3", secure, o[1:0] != 2'b10);
            chk(debug_block == secure, "R9", debug_block, secure);
        end
        // R1 nonvolatile inputs changing after reset have no effect
        do_reset(8'h5A, 8'h81);
        nv_prot = 8'hA5; nv_opt = 8'h02;
        repeat (3) @(negedge clk);
        chk(opt == 8'h81 && prot_start == 7'h2D, "R1", opt, 8'h81);
        chk(secure == 1, "R1", secure, 1);
        // R4 correct key, secure drops right after eighth write
        full_key(-1, 0);
        chk(secure == 0 && key_fail == 0, "R4", secure, 0);
        chk(debug_block == 0, "R9", debug_block, 0);
        repeat (5) @(negedge clk);
        chk(secure == 0, "R4", secure, 0);
        // R10 reset re-secures
        do_reset(8'h00, 8'h81);
        @(negedge clk);
        chk(secure == 1, "R10", secure, 1);
        // R5 key disabled
        do_reset(8'h00, 8'h01);
        full_key(-1, 0);
        chk(secure == 1 && key_fail == 0, "R5", secure, 1);
        full_key(3, 0);
        chk(key_fail == 0, "R5", key_fail, 0);
        // R6 debug writes ignored, including out of order
        do_reset(8'h00, 8'h80);
        full_key(-1, 1);
        chk(secure == 1 && key_fail == 0, "R6", secure, 1);
        wr(0, kb(0), 0); wr(1, kb(1), 0); wr(2, kb(2), 0);
        wr(6, 8'h00, 1);
        chk(key_fail == 0, "R6", key_fail, 0);
        for (int i = 3; i < 8; i++) wr(i, kb(i), 0);
        chk(secure == 0, "R6", secure, 0);
        // R7 mismatch at every byte position
        for (int b = 0; b < 8; b++) begin
            do_reset(8'h00, 8'h83);
            full_key(b, 0);
            chk(key_fail == 1 && secure == 1, "R7", key_fail, 1);
            @(negedge clk);
            chk(key_fail == 0, "R7", key_fail, 0);
            full_key(-1, 0);
            chk(secure == 1 && key_fail == 0, "R7", secure, 1);
        end
        // R7 out-of-order write
        do_reset(8'h00, 8'h80);
        wr(0, kb(0), 0);
        wr(2, kb(2), 0);
        chk(key_fail == 1, "R7", key_fail, 1);
        @(negedge clk);
        chk(key_fail == 0, "R7", key_fail, 0);
        full_key(-1, 0);
        chk(secure == 1, "R7", secure, 1);
        // R8 blank check paths
        do_reset(8'h00, 8'h00);
        blank_done = 1; blank_pass = 1; @(negedge clk); blank_done = 0;
        chk(secure == 1, "R8", secure, 1);
        mass_erase = 1; @(negedge clk); mass_erase = 0;
        blank_done = 1; blank_pass = 0; @(negedge clk); blank_done = 0;
        chk(secure == 1, "R8", secure, 1);
        blank_done = 1; blank_pass = 1; @(negedge clk); blank_done = 0;
        chk(secure == 1, "R8", secure, 1);
        mass_erase = 1; @(negedge clk); mass_erase = 0;
        chk(secure == 1, "R8", secure, 1);
        blank_done = 1; blank_pass = 1; @(negedge clk); blank_done = 0; blank_pass = 0;
        chk(secure == 0 && debug_block == 0, "R8", secure, 0);
        do_reset(8'h00, 8'h00);
        @(negedge clk);
        chk(secure == 1, "R10", secure, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule